// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes over an asynchronous serial line. Software writes a byte into a holding register and then clears the "holding register empty" flag. When the transmitter is enabled and idle, it moves the byte into an internal shift register on the next baud tick. It then sets the empty flag again, so software can queue the next byte while the current frame is still going out. Every serial bit lasts sixteen baud ticks.

A frame has a low start bit, then seven or eight data bits sent least significant bit first. An optional extra bit follows, which is even parity, odd parity, or a software-supplied multiprocessor bit. The frame ends with one or two high stop bits. Which frame to send next is decided at the end of the last stop bit. If a byte is waiting, the next start bit follows with no gap. If not, the transmit-end flag is raised and the line rests high. Each flag drives an interrupt output, gated by its own enable.

Top module: `sertx_core`

## Requirements
- R1: After reset the line `txd` is 1, `flag_empty` is 1 and `flag_end` is 1.
- R2: When transmission is enabled, the sequencer is idle and `flag_empty` is 0, the byte moves into the shift register at the next baud tick and `flag_empty` becomes 1 at that edge.
- R3: A frame starts with one 0 bit, followed by the data bits least significant first: eight bits, or seven when control bit 3 is 1.
- R4: With control bit 4 set, a parity bit follows the data. Even parity is used when control bit 5 is 0 and odd parity when it is 1. Parity covers only the configured data bits, so in 7-bit mode data bit 7 has no effect on the line.
- R5: With control bit 7 set, the extra bit is the stored multiprocessor bit (command 3, data bit 0), which replaces parity. With control bits 4 and 7 both clear, no extra bit is sent.
- R6: One stop bit of 1 is sent, or two when control bit 6 is 1.
- R7: Each serial bit lasts exactly 16 baud ticks, and the line changes only in the cycle after a tick.
- R8: If `flag_empty` is 0 when the last stop bit ends, the next start bit begins in the next cycle with no idle gap.
- R9: If `flag_empty` is 1 when the last stop bit ends, `flag_end` becomes 1 and the line stays 1.
- R10: `irq_empty` equals `flag_empty` AND control bit 1, and `irq_end` equals `flag_end` AND control bit 2.
- R11: A flag-clear command (command 2 with data bit 0 set) clears both `flag_empty` and `flag_end`.
- R12: While control bit 0 (transmit enable) is 0, the line is 1, no byte is loaded, and any frame in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_sel | input | 2 | Command: 0 data byte, 1 control word, 2 flag clear, 3 multiprocessor bit |
| wr_data | input | 8 | Write value |
| baud_tick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| txd | output | 1 | Serial output, 1 when idle |
| flag_empty | output | 1 | Holding register free |
| flag_end | output | 1 | Transmission finished, line idle |
| irq_empty | output | 1 | Data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
Single frames are sent under each framing (8-bit even and odd parity, 7-bit with and without parity, multiprocessor bit 0 and 1, two stop bits). This separates bit ordering, parity scope and extra-bit selection. Two pairs of 7-bit frames differ only in data bit 7, which shows that this bit is ignored. A byte queued during a frame shows whether the hand-off has no gap, compared with an empty register ending in the idle mark. Tick spacings of one, three and five clocks confirm that timing follows ticks and not clocks. Disabling the transmitter before a load and again mid-frame confirms that nothing is loaded and the frame is dropped.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_XBIT,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  typedef struct packed {
    logic mp_on;
    logic stop2;
    logic par_odd;
    logic par_on;
    logic short_len;
  } frame_cfg_t;

  // parity over the configured data bits only
  function automatic logic parity_of(input logic [DATA_W-1:0] d,
                                     input logic short_len,
                                     input logic odd);
    logic [DATA_W-1:0] m;
    m = d;
    if (short_len) m[DATA_W-1] = 1'b0;
    return odd ^ (^m);
  endfunction

  // bit that follows the data field, if any
  function automatic logic extra_bit(input logic [DATA_W-1:0] d,
                                     input frame_cfg_t c,
                                     input logic mpb);
    return c.mp_on ? mpb : parity_of(d, c.short_len, c.par_odd);
  endfunction

endpackage

// File: rtl/sertx_bitclk.sv
module sertx_bitclk #(
  parameter int TPB = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int CW = (TPB < 2) ? 1 : $clog2(TPB);
  localparam logic [CW-1:0] LAST = CW'(TPB - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run)    cnt <= '0;
    else if (tick)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign bit_end = run & tick & (cnt == LAST);

  // R7: a bit period always begins from a cleared count
  p_fresh_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  frame_cfg_t    load_cfg,
  input  logic          load_mpb,
  input  logic          bit_end,
  output logic          txd,
  output logic          busy,
  output logic          frame_done
);
  localparam int BCW = $clog2(DW);

  tx_state_e      st;
  logic [DW-1:0]  sh;
  logic [BCW-1:0] bidx;
  frame_cfg_t     cfg;
  logic           xb;

  logic [BCW-1:0] last_idx;
  logic           has_x;

  assign last_idx   = cfg.short_len ? BCW'(DW - 2) : BCW'(DW - 1);
  assign has_x      = cfg.mp_on | cfg.par_on;
  assign frame_done = bit_end & (((st == ST_STOP1) & ~cfg.stop2) | (st == ST_STOP2));
  assign busy       = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      sh   <= '0;
      bidx <= '0;
      cfg  <= '0;
      xb   <= 1'b0;
    end else if (!en) begin
      st <= ST_IDLE;
    end else if (load) begin
      st   <= ST_START;
      sh   <= load_data;
      cfg  <= load_cfg;
      xb   <= extra_bit(load_data, load_cfg, load_mpb);
      bidx <= '0;
    end else if (bit_end) begin
      case (st)
        ST_START: st <= ST_DATA;
        ST_DATA: begin
          sh <= sh >> 1;
          if (bidx == last_idx) st <= has_x ? ST_XBIT : ST_STOP1;
          else                  bidx <= bidx + 1'b1;
        end
        ST_XBIT:  st <= ST_STOP1;
        ST_STOP1: st <= cfg.stop2 ? ST_STOP2 : ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      ST_XBIT:  txd = xb;
      default:  txd = 1'b1;
    endcase
  end

  // R3: the cycle after a load shows the start bit
  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);

  // R7: the sequencer moves only on a bit boundary or a load
  p_hold_between_ticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load && !bit_end) |=> $stable(st));

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic cpu_clr,
  input  logic end_set,
  input  logic ie_empty,
  input  logic ie_end,
  output logic empty_f,
  output logic end_f,
  output logic irq_empty,
  output logic irq_end
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_f <= 1'b1;
      end_f   <= 1'b1;
    end else begin
      if (load)         empty_f <= 1'b1;
      else if (cpu_clr) empty_f <= 1'b0;
      if (cpu_clr)      end_f   <= 1'b0;
      else if (end_set) end_f   <= 1'b1;
    end
  end

  assign irq_empty = empty_f & ie_empty;
  assign irq_end   = end_f & ie_end;

  // R2: handing a byte to the shifter frees the holding register
  p_load_marks_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> empty_f);

  // R11: a clear command drops the end flag
  p_clear_drops_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clr |=> !end_f);

endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              flag_empty,
  output logic              flag_end,
  output logic              irq_empty,
  output logic              irq_end
);
  localparam logic [1:0] CMD_DATA = 2'd0;
  localparam logic [1:0] CMD_CTRL = 2'd1;
  localparam logic [1:0] CMD_CLR  = 2'd2;
  localparam logic [1:0] CMD_MPB  = 2'd3;

  logic [DATA_W-1:0] hold_q;
  logic              tx_on, ie_e, ie_t, mpb_q;
  frame_cfg_t        cfg_q;

  logic busy, frame_done, bit_end, load, cpu_clr, end_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      tx_on  <= 1'b0;
      ie_e   <= 1'b0;
      ie_t   <= 1'b0;
      cfg_q  <= '0;
      mpb_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_sel)
        CMD_DATA: hold_q <= wr_data;
        CMD_CTRL: begin
          tx_on           <= wr_data[0];
          ie_e            <= wr_data[1];
          ie_t            <= wr_data[2];
          cfg_q.short_len <= wr_data[3];
          cfg_q.par_on    <= wr_data[4];
          cfg_q.par_odd   <= wr_data[5];
          cfg_q.stop2     <= wr_data[6];
          cfg_q.mp_on     <= wr_data[7];
        end
        CMD_MPB:  mpb_q <= wr_data[0];
        default:  ;
      endcase
    end
  end

  assign cpu_clr = wr_en & (wr_sel == CMD_CLR) & wr_data[0];
  assign load    = tx_on & baud_tick & ~flag_empty & (~busy | frame_done);
  assign end_set = frame_done & flag_empty;

  sertx_bitclk #(.TPB(TICKS_PER_BIT)) u_bitclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy & tx_on),
    .tick    (baud_tick),
    .bit_end (bit_end)
  );

  sertx_frame #(.DW(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (tx_on),
    .load       (load),
    .load_data  (hold_q),
    .load_cfg   (cfg_q),
    .load_mpb   (mpb_q),
    .bit_end    (bit_end),
    .txd        (txd),
    .busy       (busy),
    .frame_done (frame_done)
  );

  sertx_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .cpu_clr   (cpu_clr),
    .end_set   (end_set),
    .ie_empty  (ie_e),
    .ie_end    (ie_t),
    .empty_f   (flag_empty),
    .end_f     (flag_end),
    .irq_empty (irq_empty),
    .irq_end   (irq_end)
  );

  // R12: a disabled transmitter rests at mark
  p_mark_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> txd);

  // R8: a waiting byte follows the stop bit with no gap
  p_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !flag_empty) |=> !txd);

  // R9: nothing waiting means end flag and idle mark
  p_end_then_mark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (end_set && !cpu_clr) |=> (txd && flag_end));

endmodule

// File: tb/sim_sertx_core.sv
module sim_sertx_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       baud_tick = 1'b0;
  logic       txd, flag_empty, flag_end, irq_empty, irq_end;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  int tick_per = 3;
  int tick_ctr = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  sertx_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .baud_tick(baud_tick), .txd(txd), .flag_empty(flag_empty), .flag_end(flag_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  // ---------------- behavioural reference ----------------
  bit       m_q[$];
  bit       m_busy, m_empty, m_end, m_mpb;
  int       m_idx, m_cnt;
  bit [7:0] m_data, m_ctrl;

  task automatic build_frame();
    int n;
    bit p;
    m_q.delete();
    m_q.push_back(1'b0);
    n = m_ctrl[3] ? 7 : 8;
    p = 1'b0;
    for (int i = 0; i < n; i++) begin
      m_q.push_back(m_data[i]);
      p = p ^ m_data[i];
    end
    if (m_ctrl[7])      m_q.push_back(m_mpb);
    else if (m_ctrl[4]) m_q.push_back(m_ctrl[5] ? ~p : p);
    m_q.push_back(1'b1);
    if (m_ctrl[6]) m_q.push_back(1'b1);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_empty = 1; m_end = 1; m_mpb = 0;
      m_idx = 0; m_cnt = 0; m_data = 0; m_ctrl = 0;
      m_q.delete();
    end else begin
      bit old_empty, ld, es, clr;
      old_empty = m_empty;
      ld = 0; es = 0;
      clr = wr_en && (wr_sel == 2'd2) && wr_data[0];
      if (!m_ctrl[0]) m_busy = 0;
      else if (baud_tick) begin
        if (!m_busy) ld = !old_empty;
        else begin
          m_cnt++;
          if (m_cnt == 16) begin
            m_cnt = 0;
            m_idx++;
            if (m_idx == m_q.size()) begin
              if (!old_empty) ld = 1;
              else begin m_busy = 0; es = 1; end
            end
          end
        end
      end
      if (ld) begin build_frame(); m_busy = 1; m_idx = 0; m_cnt = 0; end
      if (es) m_end = 1;
      if (clr) begin m_empty = 0; m_end = 0; end
      if (ld) m_empty = 1;
      if (wr_en) begin
        case (wr_sel)
          2'd0: m_data = wr_data;
          2'd1: m_ctrl = wr_data;
          2'd3: m_mpb = wr_data[0];
          default: ;
        endcase
      end
    end
  end

  function automatic bit m_txd();
    return m_busy ? m_q[m_idx] : 1'b1;
  endfunction

  // ---------------- stimulus helpers ----------------
  always @(negedge clk) begin
    tick_ctr++;
    baud_tick = (tick_ctr % tick_per) == 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // every-clock comparison with the reference
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(txd == m_txd(), {cur_req, " txd"}, txd, m_txd());
      chk(flag_empty == m_empty, {cur_req, " flag_empty"}, flag_empty, m_empty);
      chk(flag_end == m_end, {cur_req, " flag_end"}, flag_end, m_end);
      chk(irq_empty == (m_empty & m_ctrl[1]), "R10 irq_empty", irq_empty, m_empty & m_ctrl[1]);
      chk(irq_end == (m_end & m_ctrl[2]), "R10 irq_end", irq_end, m_end & m_ctrl[2]);
    end
    if (cyc >= 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_busy || !m_empty) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    wr(2'd0, d);
    wr(2'd2, 8'h01);
    wait_idle();
  endtask

  // control word bits: 0 enable, 1 empty irq, 2 end irq, 3 seven-bit,
  // 4 parity on, 5 odd, 6 two stop, 7 multiprocessor bit
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(flag_empty == 1'b1, "R1 flag_empty", flag_empty, 1);
    chk(flag_end == 1'b1, "R1 flag_end", flag_end, 1);

    cur_req = "R4";                       // 8-bit even parity, R3 ordering
    wr(2'd1, 8'h17); send(8'hA5); send(8'h01);
    wr(2'd1, 8'h37); send(8'h3C); send(8'h80);   // odd parity

    cur_req = "R3";                       // 7-bit, no extra bit
    wr(2'd1, 8'h0F); send(8'h55); send(8'hD5);
    cur_req = "R4";                       // 7-bit parity ignores bit 7
    wr(2'd1, 8'h1F); send(8'h41); send(8'hC1);

    cur_req = "R5";
    wr(2'd1, 8'h87); wr(2'd3, 8'h01); send(8'h96);
    wr(2'd3, 8'h00); send(8'h96);

    cur_req = "R6";
    wr(2'd1, 8'h47); send(8'hF0);

    cur_req = "R8";                       // queue a second byte mid-frame
    wr(2'd1, 8'h17);
    wr(2'd0, 8'h11); wr(2'd2, 8'h01);
    while (!flag_empty) @(negedge clk);
    wr(2'd0, 8'hEE); wr(2'd2, 8'h01);
    chk(flag_end == 1'b0, "R8 flag_end while queued", flag_end, 0);
    wait_idle();
    cur_req = "R9";
    chk(flag_end == 1'b1, "R9 flag_end after drain", flag_end, 1);
    chk(txd == 1'b1, "R9 idle mark", txd, 1);

    cur_req = "R11";
    wr(2'd0, 8'h5A);
    chk(flag_end == 1'b1, "R11 end before clear", flag_end, 1);
    wr(2'd2, 8'h01);
    chk(flag_end == 1'b0, "R11 end after clear", flag_end, 0);
    wait_idle();

    cur_req = "R10";                      // interrupts masked
    wr(2'd1, 8'h11); send(8'h33);
    chk(irq_end == 1'b0, "R10 masked end irq", irq_end, 0);
    chk(irq_empty == 1'b0, "R10 masked empty irq", irq_empty, 0);

    cur_req = "R7";
    wr(2'd1, 8'h17);
    tick_per = 1; send(8'h69);
    tick_per = 5; send(8'h2B);
    tick_per = 3;

    cur_req = "R12";
    wr(2'd1, 8'h16);                      // disabled
    wr(2'd0, 8'h00); wr(2'd2, 8'h01);
    repeat (200) @(negedge clk);
    chk(flag_empty == 1'b0, "R12 no load while off", flag_empty, 0);
    chk(txd == 1'b1, "R12 mark while off", txd, 1);
    wr(2'd1, 8'h17);
    while (!flag_empty) @(negedge clk);
    repeat (100) @(negedge clk);
    wr(2'd1, 8'h16);                      // abandon mid-frame
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R12 frame dropped", txd, 1);
    repeat (300) @(negedge clk);
    chk(txd == 1'b1, "R12 stays at mark", txd, 1);
    wr(2'd1, 8'h17);
    send(8'hC3);

    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule